// File: doc/BRIEF.md
# Dedicated Charging Port Auto-Detect Sequencer

This block chooses which charging signature a downstream USB port places on its data lines while the port runs in automatic dedicated-charging mode. It opens with the 1 A divider signature. If the load current stays high, it moves up to the 2 A divider and then to the 2.4 A divider. When the current falls away it drops back to the 1 A divider.

If a battery-charging compliant device drives a data line, the block takes a second path. It requests a VBUS discharge with the power switch off. It then turns the switch back on and presents a shorted 1.2 V signature for a timed phase. After that it settles in the standard shorted signature and stays there until the device lets go of the line.

Analog drivers, comparators and current sensing live outside the block and arrive as synchronous flags. The two load-current flags each pass through a persistence filter before the sequencer acts on them. The parent controller owns the block through the auto-mode enable. When that enable is low, the block requests nothing.

Top module: `dcp_auto_seq`

## Requirements
- R1: While `auto_en_i` is low, from the next clock edge on, `sig_o` is 0 (no signature), and `dischg_o` and `pwr_en_o` are both low. Both current filters are cleared.
- R2: One edge after `auto_en_i` rises from idle, `sig_o` is 1 (2.0 V on D+, 2.7 V on D-) and `pwr_en_o` is high.
- R3: A current flag only changes its filtered value after it has held its new level for FILT consecutive clock edges. A pulse shorter than FILT edges has no effect on `sig_o`.
- R4: In the 1 A divider state, a filtered `load_hi_i` moves `sig_o` to 2 (2.7 V on D+, 2.0 V on D-) one edge after the filter qualifies.
- R5: In the 2 A divider state, a filtered `load_top_i` moves `sig_o` to 3 (2.7 V on both lines). Code 3 is only ever entered from code 2.
- R6: If filtered `load_top_i` falls in code 3, or filtered `load_hi_i` falls in code 2, `sig_o` returns to 1.
- R7: In code 1, `dev_drive_i` starts a discharge on the next edge: `sig_o`=0, `dischg_o`=1, `pwr_en_o`=0. This takes priority over a current upgrade that matures in the same cycle. `pwr_en_o` is never high while `dischg_o` is high.
- R8: The discharge ends after DISCH_CYC cycles, or on the edge that samples `vbus_low_i` high, whichever comes first. The block then enters `sig_o`=4 (both lines shorted at 1.2 V) with `pwr_en_o`=1. Code 4 is only entered from a discharge.
- R9: Code 4 lasts exactly V12_CYC cycles and is followed by `sig_o`=5 (lines shorted together).
- R10: Code 5 holds and ignores both current flags until `line_rel_i` is sampled high. The next edge then returns `sig_o` to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| auto_en_i | input | 1 | Automatic charging mode enable from the parent controller |
| dev_drive_i | input | 1 | Attached device drives a data line (compliant device detected) |
| line_rel_i | input | 1 | Device has released the data line |
| load_hi_i | input | 1 | Load current above 0.9 A |
| load_top_i | input | 1 | Load current above 1.8 A |
| vbus_low_i | input | 1 | VBUS has fallen below the discharged level |
| sig_o | output | 3 | Signature code: 0 none, 1 div-1A, 2 div-2A, 3 div-2.4A, 4 shorted 1.2 V, 5 shorted |
| dischg_o | output | 1 | VBUS discharge request |
| pwr_en_o | output | 1 | Power switch enable request |

## Verification
Two events can land on the same edge in the 1 A divider state: the load filter qualifying `load_hi_i`, and a device driving the data line. The bench holds `load_hi_i` for exactly FILT edges and raises `dev_drive_i` on that same edge. It then expects the discharge, not the 2 A divider, on the following edge. A second overlap occurs in the shorted state, where a sustained high load is applied. The sequencer must stay put and move only on `line_rel_i`.

// File: rtl/dcp_auto_pkg.sv
package dcp_auto_pkg;
  typedef enum logic [2:0] {
    SIG_NONE    = 3'd0,
    SIG_DIV1A   = 3'd1,
    SIG_DIV2A   = 3'd2,
    SIG_DIV24   = 3'd3,
    SIG_SHORT12 = 3'd4,
    SIG_BCSHORT = 3'd5
  } dcp_sig_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_D1, ST_D2, ST_D24, ST_DIS, ST_V12, ST_BC
  } dcp_st_e;
endpackage

// File: rtl/dcp_flag_filter.sv
module dcp_flag_filter #(
  parameter int unsigned FILT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic raw_i,
  output logic flt_o
);
  localparam int unsigned CW = $clog2(FILT + 1);

  logic [CW-1:0] cnt_q;
  logic          flt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      flt_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      flt_q <= 1'b0;
    end else if (raw_i == flt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(FILT - 1)) begin
      cnt_q <= '0;
      flt_q <= raw_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign flt_o = flt_q;
endmodule

// File: rtl/dcp_phase_timer.sv
module dcp_phase_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (cnt_q != '1)     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dcp_auto_fsm.sv
module dcp_auto_fsm
  import dcp_auto_pkg::*;
#(
  parameter int unsigned DISCH_CYC = 200,
  parameter int unsigned V12_CYC   = 100,
  parameter int unsigned CW        = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          auto_en_i,
  input  logic          dev_drive_i,
  input  logic          line_rel_i,
  input  logic          vbus_low_i,
  input  logic          hi_flt_i,
  input  logic          top_flt_i,
  input  logic [CW-1:0] tmr_cnt_i,
  output logic          tmr_clr_o,
  output dcp_st_e       st_o
);
  dcp_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!auto_en_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: st_d = ST_D1;
        ST_D1: begin
          if (dev_drive_i)   st_d = ST_DIS;  // compliant device wins
          else if (hi_flt_i) st_d = ST_D2;
        end
        ST_D2: begin
          if (top_flt_i)     st_d = ST_D24;
          else if (!hi_flt_i) st_d = ST_D1;
        end
        ST_D24: if (!top_flt_i) st_d = ST_D1;
        ST_DIS: if (vbus_low_i || tmr_cnt_i == CW'(DISCH_CYC - 1)) st_d = ST_V12;
        ST_V12: if (tmr_cnt_i == CW'(V12_CYC - 1)) st_d = ST_BC;
        ST_BC:  if (line_rel_i) st_d = ST_D1;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign tmr_clr_o = (st_d != st_q);
  assign st_o      = st_q;
endmodule

// File: rtl/dcp_auto_seq.sv
module dcp_auto_seq
  import dcp_auto_pkg::*;
#(
  parameter int unsigned FILT      = 16,
  parameter int unsigned DISCH_CYC = 200_000_000,
  parameter int unsigned V12_CYC   = 100_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       auto_en_i,
  input  logic       dev_drive_i,
  input  logic       line_rel_i,
  input  logic       load_hi_i,
  input  logic       load_top_i,
  input  logic       vbus_low_i,
  output logic [2:0] sig_o,
  output logic       dischg_o,
  output logic       pwr_en_o
);
  localparam int unsigned NFLAG = 2;
  localparam int unsigned TMAX  = (DISCH_CYC > V12_CYC) ? DISCH_CYC : V12_CYC;
  localparam int unsigned CW    = $clog2(TMAX + 1);

  logic [NFLAG-1:0] raw, flt;
  logic [CW-1:0]    tmr_cnt;
  logic             tmr_clr;
  dcp_st_e          st;

  assign raw = {load_top_i, load_hi_i};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flt
    dcp_flag_filter #(.FILT(FILT)) i_flt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (!auto_en_i),
      .raw_i  (raw[g]),
      .flt_o  (flt[g])
    );
  end

  dcp_phase_timer #(.CW(CW)) i_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .cnt_o  (tmr_cnt)
  );

  dcp_auto_fsm #(.DISCH_CYC(DISCH_CYC), .V12_CYC(V12_CYC), .CW(CW)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .auto_en_i   (auto_en_i),
    .dev_drive_i (dev_drive_i),
    .line_rel_i  (line_rel_i),
    .vbus_low_i  (vbus_low_i),
    .hi_flt_i    (flt[0]),
    .top_flt_i   (flt[1]),
    .tmr_cnt_i   (tmr_cnt),
    .tmr_clr_o   (tmr_clr),
    .st_o        (st)
  );

  always_comb begin
    sig_o    = SIG_NONE;
    dischg_o = 1'b0;
    pwr_en_o = 1'b1;
    unique case (st)
      ST_IDLE: pwr_en_o = 1'b0;
      ST_D1:   sig_o = SIG_DIV1A;
      ST_D2:   sig_o = SIG_DIV2A;
      ST_D24:  sig_o = SIG_DIV24;
      ST_DIS: begin
        dischg_o = 1'b1;
        pwr_en_o = 1'b0;
      end
      ST_V12:  sig_o = SIG_SHORT12;
      ST_BC:   sig_o = SIG_BCSHORT;
      default: pwr_en_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dcp_auto_seq_chk.sv
module dcp_auto_seq_chk
  import dcp_auto_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       auto_en_i,
  input logic       line_rel_i,
  input logic [2:0] sig_o,
  input logic       dischg_o,
  input logic       pwr_en_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en_i |=> (sig_o == SIG_NONE && !dischg_o && !pwr_en_o));

  assert_div24_from_div2a_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_o == SIG_DIV24 && $past(sig_o) != SIG_DIV24) |-> $past(sig_o) == SIG_DIV2A);

  assert_no_power_in_discharge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dischg_o |-> !pwr_en_o);

  assert_short12_after_discharge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_o == SIG_SHORT12 && $past(sig_o) != SIG_SHORT12) |-> $past(dischg_o));

  assert_short12_powered_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_o == SIG_SHORT12) |-> pwr_en_o);

  assert_bc_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_o == SIG_BCSHORT && auto_en_i && !line_rel_i) |=> sig_o == SIG_BCSHORT);
endmodule

bind dcp_auto_seq dcp_auto_seq_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .auto_en_i  (auto_en_i),
  .line_rel_i (line_rel_i),
  .sig_o      (sig_o),
  .dischg_o   (dischg_o),
  .pwr_en_o   (pwr_en_o)
);

// File: tb/test_dcp_auto_seq.sv
module test_dcp_auto_seq;
  localparam int unsigned FILT = 4;
  localparam int unsigned DIS  = 20;
  localparam int unsigned V12  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_en = 1'b0, dev_drive = 1'b0, line_rel = 1'b0;
  logic load_hi = 1'b0, load_top = 1'b0, vbus_low = 1'b0;
  logic [2:0] sig;
  logic dischg, pwr_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [2:0] sig;
    logic       dis;
    logic       pwr;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  dcp_auto_seq #(.FILT(FILT), .DISCH_CYC(DIS), .V12_CYC(V12)) i_dcp_auto_seq (
    .clk_i(clk), .rst_ni(rst_n), .auto_en_i(auto_en), .dev_drive_i(dev_drive),
    .line_rel_i(line_rel), .load_hi_i(load_hi), .load_top_i(load_top),
    .vbus_low_i(vbus_low), .sig_o(sig), .dischg_o(dischg), .pwr_en_o(pwr_en)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(logic [2:0] s, logic d, logic p, string tag);
    exp_t e;
    e.sig = s; e.dis = d; e.pwr = p; e.tag = tag;
    sb.push_back(e);
    #2;
  endtask

  // monitor: compares pushed expectations 1 ns after the driver posts them
  initial begin
    forever begin
      wait (sb.size() != 0);
      #1;
      begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (sig !== e.sig || dischg !== e.dis || pwr_en !== e.pwr) begin
          fails++;
          $display("FAIL %s actual sig=%0d dis=%0b pwr=%0b expected sig=%0d dis=%0b pwr=%0b",
                   e.tag, sig, dischg, pwr_en, e.sig, e.dis, e.pwr);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(2);
    expect_out(3'd0, 1'b0, 1'b0, "R1 reset");
    rst_n = 1'b1;
    step(2);
    expect_out(3'd0, 1'b0, 1'b0, "R1 idle disabled");

    auto_en = 1'b1; step(1);
    expect_out(3'd1, 1'b0, 1'b1, "R2 entry div1A");

    // R3: pulse of FILT-1 edges ignored
    load_hi = 1'b1; step(FILT - 1);
    load_hi = 1'b0; step(5);
    expect_out(3'd1, 1'b0, 1'b1, "R3 short pulse ignored");

    // R4: sustained load above 0.9 A
    load_hi = 1'b1; step(FILT);
    expect_out(3'd1, 1'b0, 1'b1, "R3 not yet qualified");
    step(1);
    expect_out(3'd2, 1'b0, 1'b1, "R4 div2A");

    // R5
    load_top = 1'b1; step(FILT);
    expect_out(3'd2, 1'b0, 1'b1, "R5 still div2A");
    step(1);
    expect_out(3'd3, 1'b0, 1'b1, "R5 div2.4A");

    // R6: top falls, hi stays -> back to 1A then up to 2A
    load_top = 1'b0; step(FILT + 1);
    expect_out(3'd1, 1'b0, 1'b1, "R6 revert from 2.4A");
    step(1);
    expect_out(3'd2, 1'b0, 1'b1, "R4 re-upgrade");
    load_hi = 1'b0; step(FILT);
    expect_out(3'd2, 1'b0, 1'b1, "R6 hold before qualify");
    step(1);
    expect_out(3'd1, 1'b0, 1'b1, "R6 revert from 2A");

    // R7/R8/R9: compliant device, full discharge timeout
    dev_drive = 1'b1; step(1);
    expect_out(3'd0, 1'b1, 1'b0, "R7 discharge");
    dev_drive = 1'b0; step(DIS - 1);
    expect_out(3'd0, 1'b1, 1'b0, "R8 discharge last cycle");
    step(1);
    expect_out(3'd4, 1'b0, 1'b1, "R8 shorted 1.2V");
    step(V12 - 1);
    expect_out(3'd4, 1'b0, 1'b1, "R9 1.2V last cycle");
    step(1);
    expect_out(3'd5, 1'b0, 1'b1, "R9 shorted");

    // R10: load flags ignored in shorted state
    load_hi = 1'b1; load_top = 1'b1; step(2 * FILT + 2);
    expect_out(3'd5, 1'b0, 1'b1, "R10 load ignored");
    load_hi = 1'b0; load_top = 1'b0; step(FILT + 2);
    line_rel = 1'b1; step(1);
    expect_out(3'd1, 1'b0, 1'b1, "R10 release to div1A");
    line_rel = 1'b0;

    // R8: early exit on VBUS low
    dev_drive = 1'b1; step(1);
    dev_drive = 1'b0; step(3);
    expect_out(3'd0, 1'b1, 1'b0, "R8 discharge early");
    vbus_low = 1'b1; step(1);
    expect_out(3'd4, 1'b0, 1'b1, "R8 vbus low exit");
    vbus_low = 1'b0;
    step(V12);
    expect_out(3'd5, 1'b0, 1'b1, "R9 shorted again");
    line_rel = 1'b1; step(1);
    line_rel = 1'b0;
    expect_out(3'd1, 1'b0, 1'b1, "R10 release again");

    // R7: device drive and load qualification on the same edge
    load_hi = 1'b1; step(FILT);
    dev_drive = 1'b1; step(1);
    expect_out(3'd0, 1'b1, 1'b0, "R7 priority over upgrade");
    dev_drive = 1'b0; load_hi = 1'b0;

    // R1: disable mid-discharge
    auto_en = 1'b0; step(1);
    expect_out(3'd0, 1'b0, 1'b0, "R1 disable during discharge");
    step(3);
    expect_out(3'd0, 1'b0, 1'b0, "R1 stays idle");
    auto_en = 1'b1; step(1);
    expect_out(3'd1, 1'b0, 1'b1, "R2 re-entry div1A");
    step(FILT + 2);
    expect_out(3'd1, 1'b0, 1'b1, "R1 filters cleared");

    step(2);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule